// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block makes a small byte-wide serial EEPROM on an SPI bus, running in mode 0. The bus master selects the device, shifts in an 8-bit command code and, for array commands, an 8-bit address. After that it either streams data out or streams data in. The storage is a register array inside the chip, so contents are lost at reset. Everything runs on the system clock. The chip-select, serial-clock and data-in pins pass through synchronizers, and the block acts on the serial-clock edges it detects. The serial clock must therefore be clearly slower than the system clock.

Writes are gated by a write-enable latch. The latch clears itself once a write command ends. Each write or status write is followed by a busy window of programmable length, counted in system clocks. During that window the device answers only status reads. Page writes wrap inside an aligned block of eight bytes. Three block-protect bits make the upper part of the array read-only. A build option takes a ninth address bit from bit 3 of the command byte, for arrays larger than 256 bytes.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset the status byte reads 0x00, every array byte reads 0x00, and the serial data output is low.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The status byte holds:
  - bit 0: busy
  - bit 1: write-enable latch
  - bits 4:2: block-protect code
  - bit 7: protect-enable flag
  - bits 6:5: always 0
- R3: Command 0x03 followed by an address returns array bytes MSB first. The device changes its output on the serial-clock falling edge and samples input on the rising edge. A read keeps incrementing the address while select stays low, and wraps from the last byte to byte 0. The address is taken modulo the array size.
- R4: Command 0x02 followed by an address and data bytes stores each complete byte. The address increments only inside its aligned 8-byte block, so byte 7 of the block is followed by byte 0 of the same block.
- R5: A write (0x02) or status write (0x01) received while the write-enable latch is clear is ignored.
- R6: When select is released after an accepted write or status write, the write-enable latch clears.
- R7: After such a release the busy bit reads 1 for BUSY_CYCLES system clocks. While busy, every command except 0x05 is ignored, and an ignored read returns 0x00.
- R8: Command 0x01 with the latch set stores data bits 7 and 4:2 into the status byte. The other status bits cannot be written this way.
- R9: With block-protect code p, writes to the top p/8 of the array are suppressed. For 128 bytes and p=1, that is addresses 0x70 to 0x7F.
- R10: Releasing select in the middle of a byte discards that byte. A partial command byte has no effect, and the complete data bytes sent before it are kept.
- R11: With ADDR_MUNGE=1, opcode bit 3 is address bit 8. 0x0A and 0x0B then write and read the upper 256 bytes.
- R12: Command 0x05 returns the live status byte, repeated for every byte while select is held low.
- R13: An unknown command code changes nothing, and the data output stays low for the rest of that selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
Each piece of hidden state shows up at the pins at a known point. A wrong write-enable latch or busy count appears in the very next status read: a status byte that is one bit off, or a command that is accepted or dropped when it should not be. A corrupted address pointer or page-wrap step gives the wrong byte on the first read that walks over the affected location. An early or late end to the busy window shows as a status poll that reports the wrong busy bit.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WREN = 8'h06;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ADDR,
    ST_RDAT,
    ST_WDAT,
    ST_RSTAT,
    ST_WSTAT,
    ST_SKIP
  } eep_state_e;

endpackage

// File: rtl/eep_reset_sync.sv
module eep_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_sync = rs_q[1];
endmodule

// File: rtl/eep_pin_sync.sv
module eep_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic mosi_pin,
  output logic cs_act,
  output logic cs_end,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_bit
);
  logic [2:0] cs_q;
  logic [2:0] sck_q;
  logic [1:0] mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n_pin};
      sck_q  <= {sck_q[1:0], sck_pin};
      mosi_q <= {mosi_q[0], mosi_pin};
    end
  end

  assign cs_act   = ~cs_q[1];
  assign cs_end   = cs_q[1] & ~cs_q[2];
  assign sck_rise = cs_act & sck_q[1] & ~sck_q[2];
  assign sck_fall = cs_act & ~sck_q[1] & sck_q[2];
  assign mosi_bit = mosi_q[1];

  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> !cs_act);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [7:0] word_q;
    logic       word_en;

    assign word_en = we && (waddr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= 8'h00;
      else if (word_en) word_q <= wdata;
    end

    assign words[g] = word_q;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
  import eep_pkg::*;
#(
  parameter int DEPTH       = 128,
  parameter int BLOCK       = 8,
  parameter int BUSY_CYCLES = 600,
  parameter int ADDR_MUNGE  = 0,
  localparam int AW = $clog2(DEPTH),
  localparam int BW = $clog2(BLOCK),
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_act,
  input  logic          cs_end,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_bit,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          miso
);
  localparam int EIGHTH = DEPTH / 8;

  eep_state_e    state_q, state_n;
  logic [2:0]    bit_q, bit_n;
  logic [6:0]    rx_q, rx_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          a8_q, a8_n;
  logic          is_wr_q, is_wr_n;
  logic          wel_q, wel_n;
  logic [2:0]    bp_q, bp_n;
  logic          wpen_q, wpen_n;
  logic [CW-1:0] busy_q, busy_n;
  logic [7:0]    tx_q, tx_n;
  logic          miso_q, miso_n;
  logic          wcmd_q, wcmd_n;

  logic          byte_done;
  logic [7:0]    byte_in;
  logic [7:0]    op_c;
  logic [8:0]    addr_full;
  logic [AW-1:0] new_addr;
  logic [AW-1:0] page_next;
  logic [AW:0]   prot_base;
  logic          prot_hit;
  logic          busy;
  logic [7:0]    status_c;

  assign byte_done = sck_rise && (bit_q == 3'd7);
  assign byte_in   = {rx_q, mosi_bit};
  assign op_c      = (ADDR_MUNGE != 0) ? (byte_in & 8'hF7) : byte_in;
  assign addr_full = {(ADDR_MUNGE != 0) && a8_q, byte_in};
  assign new_addr  = AW'(addr_full);
  assign busy      = (busy_q != '0);
  assign status_c  = {wpen_q, 2'b00, bp_q, wel_q, busy};

  // Next address inside the aligned block: upper bits held, lower bits wrap.
  always_comb begin
    page_next = addr_q;
    page_next[BW-1:0] = addr_q[BW-1:0] + BW'(1);
  end

  // Protected window is the top bp/8 of the array.
  assign prot_base = (AW+1)'(DEPTH) - ((AW+1)'(bp_q) * (AW+1)'(EIGHTH));
  assign prot_hit  = ({1'b0, addr_q} >= prot_base);

  assign rd_addr = (state_q == ST_ADDR) ? new_addr : addr_q + AW'(1);
  assign wr_addr = addr_q;
  assign wr_data = byte_in;
  assign miso    = miso_q;

  always_comb begin
    state_n = state_q;
    bit_n   = bit_q;
    rx_n    = rx_q;
    addr_n  = addr_q;
    a8_n    = a8_q;
    is_wr_n = is_wr_q;
    wel_n   = wel_q;
    bp_n    = bp_q;
    wpen_n  = wpen_q;
    busy_n  = busy_q;
    tx_n    = tx_q;
    miso_n  = miso_q;
    wcmd_n  = wcmd_q;
    wr_en   = 1'b0;

    if (busy) busy_n = busy_q - CW'(1);

    if (cs_end) begin
      state_n = ST_OP;
      bit_n   = 3'd0;
      tx_n    = 8'h00;
      miso_n  = 1'b0;
      wcmd_n  = 1'b0;
      if (wcmd_q) begin
        wel_n  = 1'b0;
        busy_n = CW'(BUSY_CYCLES);
      end
    end else if (cs_act) begin
      if (sck_rise) begin
        bit_n = bit_q + 3'd1;
        rx_n  = {rx_q[5:0], mosi_bit};
      end
      if (sck_fall) begin
        miso_n = tx_q[7];
        tx_n   = {tx_q[6:0], 1'b0};
      end
      if (byte_done) begin
        unique case (state_q)
          ST_OP: begin
            a8_n    = byte_in[3];
            state_n = ST_SKIP;
            if (!busy || op_c == OPC_RDSR) begin
              unique case (op_c)
                OPC_WREN: wel_n = 1'b1;
                OPC_WRDI: wel_n = 1'b0;
                OPC_RDSR: begin
                  tx_n    = status_c;
                  state_n = ST_RSTAT;
                end
                OPC_WRSR: if (wel_q) begin
                  state_n = ST_WSTAT;
                  wcmd_n  = 1'b1;
                end
                OPC_WRITE: if (wel_q) begin
                  state_n = ST_ADDR;
                  is_wr_n = 1'b1;
                  wcmd_n  = 1'b1;
                end
                OPC_READ: begin
                  state_n = ST_ADDR;
                  is_wr_n = 1'b0;
                end
                default: state_n = ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            addr_n = new_addr;
            if (is_wr_q) begin
              state_n = ST_WDAT;
            end else begin
              state_n = ST_RDAT;
              tx_n    = rd_data;
            end
          end
          ST_RDAT: begin
            addr_n = addr_q + AW'(1);
            tx_n   = rd_data;
          end
          ST_WDAT: begin
            wr_en  = !prot_hit;
            addr_n = page_next;
          end
          ST_RSTAT: tx_n = status_c;
          ST_WSTAT: begin
            wpen_n  = byte_in[7];
            bp_n    = byte_in[4:2];
            state_n = ST_SKIP;
          end
          default: state_n = ST_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OP;
      bit_q   <= 3'd0;
      rx_q    <= 7'd0;
      addr_q  <= '0;
      a8_q    <= 1'b0;
      is_wr_q <= 1'b0;
      wel_q   <= 1'b0;
      bp_q    <= 3'd0;
      wpen_q  <= 1'b0;
      busy_q  <= '0;
      tx_q    <= 8'h00;
      miso_q  <= 1'b0;
      wcmd_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      rx_q    <= rx_n;
      addr_q  <= addr_n;
      a8_q    <= a8_n;
      is_wr_q <= is_wr_n;
      wel_q   <= wel_n;
      bp_q    <= bp_n;
      wpen_q  <= wpen_n;
      busy_q  <= busy_n;
      tx_q    <= tx_n;
      miso_q  <= miso_n;
      wcmd_q  <= wcmd_n;
    end
  end

  // R6
  wel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && wcmd_q) |=> !wel_q);

  // R7
  busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && wcmd_q) |=> (busy_q == CW'(BUSY_CYCLES)));

  // R7
  busy_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !busy);

  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wel_q);

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDAT && byte_done) |=>
      ((addr_q >> BW) == ($past(addr_q) >> BW)));

  // R10
  bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (bit_q == 3'd0));
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int DEPTH       = 128,
  parameter int BLOCK       = 8,
  parameter int BUSY_CYCLES = 600,
  parameter int ADDR_MUNGE  = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso
);
  localparam int AW = $clog2(DEPTH);

  logic          rst_n_s;
  logic          cs_act, cs_end, sck_rise, sck_fall, mosi_bit;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_en;

  eep_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eep_pin_sync u_pins (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_n_pin (spi_cs_n),
    .sck_pin  (spi_sck),
    .mosi_pin (spi_mosi),
    .cs_act   (cs_act),
    .cs_end   (cs_end),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_bit (mosi_bit)
  );

  eep_cmd_engine #(
    .DEPTH       (DEPTH),
    .BLOCK       (BLOCK),
    .BUSY_CYCLES (BUSY_CYCLES),
    .ADDR_MUNGE  (ADDR_MUNGE)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cs_act   (cs_act),
    .cs_end   (cs_end),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_bit (mosi_bit),
    .rd_data  (rd_data),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .miso     (spi_miso)
  );

  eep_store #(
    .DEPTH (DEPTH)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_n_s),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );
endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int HALF  = 8;
  localparam int BUSY  = 2000;
  localparam int WDOG  = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_a = 1'b1;
  logic cs_m = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso_a, miso_m;
  logic sel_m = 1'b0;
  logic done = 1'b0;
  int   nchk = 0;
  int   nfail = 0;
  logic [7:0] rbuf [8];
  logic [7:0] rx;

  always #2 clk = ~clk;

  spi_eeprom_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_a), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso_a));

  spi_eeprom_slave #(.DEPTH(512), .BUSY_CYCLES(BUSY), .ADDR_MUNGE(1)) dut_m (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_m), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso_m));

  // vector: {set latch first, address, data written, expected read-back}
  localparam logic [24:0] VEC [8] = '{
    {1'b1, 8'h10, 8'hA5, 8'hA5},
    {1'b0, 8'h11, 8'h3C, 8'h00},
    {1'b1, 8'h7F, 8'h81, 8'h81},
    {1'b1, 8'h00, 8'h01, 8'h01},
    {1'b0, 8'h10, 8'hFF, 8'hA5},
    {1'b1, 8'h45, 8'h6E, 8'h6E},
    {1'b1, 8'hC5, 8'h99, 8'h99},
    {1'b0, 8'h45, 8'h00, 8'h99}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      r[i] = sel_m ? miso_m : miso_a;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xbits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_on();
    if (sel_m) cs_m = 1'b0; else cs_a = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (HALF) @(negedge clk);
    cs_a = 1'b1;
    cs_m = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_on(); xbyte(op, rx); cs_off();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] b);
    cs_on(); xbyte(op, rx); xbyte(b, rx); cs_off();
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    cs_on(); xbyte(8'h02, rx); xbyte(a, rx); xbyte(d, rx); cs_off();
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, input int n);
    cs_on(); xbyte(op, rx); xbyte(a, rx);
    for (int k = 0; k < n; k++) xbyte(8'h00, rbuf[k]);
    cs_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    cs_on(); xbyte(8'h05, rx); xbyte(8'h00, s); cs_off();
  endtask

  task automatic wait_busy();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check("R1 miso idle", {7'd0, miso_a}, 8'h00);
    rdsr(s); check("R1 status", s, 8'h00);
    rd(8'h03, 8'h10, 1); check("R1 array", rbuf[0], 8'h00);

    // Table walk: R4 writes with latch, R5 writes without latch
    for (int k = 0; k < 8; k++) begin
      automatic logic [24:0] v = VEC[k];
      if (v[24]) cmd1(8'h06);
      wr1(v[23:16], v[15:8]);
      wait_busy();
      rd(8'h03, v[23:16], 1);
      check(v[24] ? "R4 write/read" : "R5 write without latch", rbuf[0], v[7:0]);
    end

    // R3 read burst wraps at array end
    rd(8'h03, 8'h7F, 2);
    check("R3 read last", rbuf[0], 8'h81);
    check("R3 read wrap", rbuf[1], 8'h01);

    // R2 latch set and clear
    cmd1(8'h06); rdsr(s); check("R2 latch set", s, 8'h02);
    cmd1(8'h04); rdsr(s); check("R2 latch clear", s, 8'h00);

    // R12 repeated status
    cmd1(8'h06);
    cs_on(); xbyte(8'h05, rx);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, s); check("R12 repeated status", s, 8'h02);
    end
    cs_off();
    cmd1(8'h04);

    // R4 page wrap inside aligned block
    cmd1(8'h06);
    cs_on(); xbyte(8'h02, rx); xbyte(8'h26, rx);
    xbyte(8'h11, rx); xbyte(8'h22, rx); xbyte(8'h33, rx); cs_off();
    wait_busy();
    rd(8'h03, 8'h20, 8);
    check("R4 wrap to block start", rbuf[0], 8'h33);
    check("R4 untouched in block", rbuf[1], 8'h00);
    check("R4 first byte", rbuf[6], 8'h11);
    check("R4 second byte", rbuf[7], 8'h22);
    rd(8'h03, 8'h28, 1); check("R4 next block untouched", rbuf[0], 8'h00);

    // R6/R7 latch clears, busy window, commands ignored while busy
    cmd1(8'h06);
    wr1(8'h30, 8'h77);
    rdsr(s); check("R6 R7 busy and latch cleared", s, 8'h01);
    rd(8'h03, 8'h30, 1); check("R7 read ignored while busy", rbuf[0], 8'h00);
    cmd1(8'h06);
    rdsr(s); check("R7 latch set ignored while busy", s, 8'h01);
    wait_busy();
    rdsr(s); check("R7 busy ends", s, 8'h00);
    rd(8'h03, 8'h30, 1); check("R7 data stored", rbuf[0], 8'h77);

    // R5 status write without latch ignored
    cmd2(8'h01, 8'h1C);
    rdsr(s); check("R5 status write without latch", s, 8'h00);

    // R8 status write masks
    cmd1(8'h06); cmd2(8'h01, 8'hFF); wait_busy();
    rdsr(s); check("R8 writable status bits", s, 8'h9C);

    // R9 block protect p=1 covers 0x70..0x7F
    cmd1(8'h06); cmd2(8'h01, 8'h04); wait_busy();
    rdsr(s); check("R8 status code 1", s, 8'h04);
    cmd1(8'h06); wr1(8'h6F, 8'h5D); wait_busy();
    cmd1(8'h06); wr1(8'h70, 8'h5D); wait_busy();
    rd(8'h03, 8'h6F, 2);
    check("R9 below window written", rbuf[0], 8'h5D);
    check("R9 protected byte kept", rbuf[1], 8'h00);
    cmd1(8'h06); cmd2(8'h01, 8'h00); wait_busy();

    // R10 partial byte discarded
    cmd1(8'h06);
    cs_on(); xbyte(8'h02, rx); xbyte(8'h50, rx); xbyte(8'h5A, rx);
    xbits(8'hF0, 4); cs_off();
    wait_busy();
    rd(8'h03, 8'h50, 2);
    check("R10 complete byte kept", rbuf[0], 8'h5A);
    check("R10 partial byte dropped", rbuf[1], 8'h00);
    cs_on(); xbits(8'h06, 4); cs_off();
    rdsr(s); check("R10 partial opcode no effect", s, 8'h00);

    // R13 unknown opcode
    cmd1(8'h06);
    cs_on(); xbyte(8'h52, rx); xbyte(8'h00, s); cs_off();
    check("R13 output low", s, 8'h00);
    rdsr(s); check("R13 state unchanged", s, 8'h02);
    cmd1(8'h04);

    // R11 ninth address bit from opcode bit 3
    sel_m = 1'b1;
    cmd1(8'h06);
    cs_on(); xbyte(8'h0A, rx); xbyte(8'h05, rx); xbyte(8'hC3, rx); cs_off();
    wait_busy();
    rd(8'h03, 8'h05, 1); check("R11 lower half untouched", rbuf[0], 8'h00);
    rd(8'h0B, 8'h05, 1); check("R11 upper half read", rbuf[0], 8'hC3);
    sel_m = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule